// File: doc/BRIEF.md
# Grouped Event Flag Combiner

This block captures a wide vector of single-cycle event inputs into sticky flag bits. The flags are organised as groups of one bus word each, with four groups of 32 by default. Software reaches the flags through a word-addressed register bus. A write-one-to-set word and a write-one-to-clear word let software change individual flags. Two independent mask words per group select which flags take part in each group's combined interrupt and in each group's combined exception.

Each group drives one combined interrupt line and one combined exception line. A handler reads the masked view of a group to find which unmasked flags are pending. It then clears the ones it has serviced through the clear word. An event that arrives in the same cycle as that clear keeps its flag set, so the event is not lost.

Top module: `evt_group_combiner`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every flag is 0, every event mask word and every exception mask word holds all ones, and all `grp_irq` and `grp_exc` lines are 0.
- R2: An `ev_in` bit that is high at a rising clock edge makes its flag 1 after that edge. The flag stays at 1 until software clears it. Event bit `g*GROUP_W + b` maps to bit `b` of group `g`.
- R3: A write to the set word of group g (word address 8+g) sets every flag bit whose written data bit is 1. Written 0 bits leave their flags unchanged.
- R4: A write to the clear word of group g (word address 16+g) clears every flag bit whose written data bit is 1. Written 0 bits leave their flags unchanged.
- R5: When an `ev_in` bit is high in the same cycle as a clear write that targets its flag, the flag ends up 1.
- R6: The event mask word of group g (address 32+g) can be read and written. The masked flag word (address 40+g) is read-only and returns the flags AND NOT the event mask, where a mask bit of 1 blocks its flag.
- R7: The exception mask word of group g (address 48+g) can be read and written. The masked exception word (address 56+g) is read-only and returns the flags AND NOT the exception mask.
- R8: `grp_irq[g]` is the OR of the masked flag bits of group g, and `grp_exc[g]` is the OR of the masked exception bits of group g. Both follow the register state in the same cycle.
- R9: These reads return 0: the words at 24..31, any word whose low three address bits name a group at or above `NUM_GROUPS`, and the set and clear words. Writes to reserved or unpopulated words, to the flag words and to the two masked views change no state.
- R10: The flag word of group g is read at address g. In every address, bits [5:3] select the register array and bits [2:0] select the group.
- R11: `bus_rdata` is combinational on `bus_addr` within the same cycle. A write takes effect at the rising edge where `bus_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | NUM_GROUPS*GROUP_W | Event inputs, one per flag |
| bus_we | input | 1 | Write enable for the register bus |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | GROUP_W | Write data |
| bus_rdata | output | GROUP_W | Read data for `bus_addr` |
| grp_irq | output | NUM_GROUPS | Combined interrupt, one per group |
| grp_exc | output | NUM_GROUPS | Combined exception, one per group |

## Verification
A single event walks through all 128 flag positions while the two mask words of each group hold complementary patterns. This shows whether the bit-to-group mapping is right, and whether the interrupt and exception paths use different masks. Dense patterns are written to the set and clear words, and all-zero words are written too. These separate write-one behaviour from plain overwrites. An event is made to coincide with a clear that covers the whole group, which shows which of the two wins. Writes aimed at reserved, unpopulated and read-only words are each followed by a full readback of every address and by a look at both output vectors. Any state that a stray decode touched would show up there.

// File: rtl/evt_comb_pkg.sv
package evt_comb_pkg;

    // Word address: [5:3] array select, [2:0] group select.
    localparam int unsigned ADDR_W     = 6;
    localparam int unsigned GRP_SEL_W  = 3;
    localparam int unsigned REGION_W   = ADDR_W - GRP_SEL_W;
    localparam int unsigned MAX_GROUPS = 1 << GRP_SEL_W;

    typedef enum logic [REGION_W-1:0] {
        RG_FLAG  = 3'd0,
        RG_SET   = 3'd1,
        RG_CLR   = 3'd2,
        RG_RSVD  = 3'd3,
        RG_EMASK = 3'd4,
        RG_EVIEW = 3'd5,
        RG_XMASK = 3'd6,
        RG_XVIEW = 3'd7
    } region_e;

    typedef struct packed {
        logic                 hit;
        region_e              region;
        logic [GRP_SEL_W-1:0] grp;
    } bus_dec_t;

    function automatic bus_dec_t decode_addr(logic [ADDR_W-1:0] a, int unsigned ngroups);
        bus_dec_t d;
        d.region = region_e'(a[ADDR_W-1:GRP_SEL_W]);
        d.grp    = a[GRP_SEL_W-1:0];
        d.hit    = ({29'd0, a[GRP_SEL_W-1:0]} < ngroups) && (d.region != RG_RSVD);
        return d;
    endfunction

endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_comb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4
) (
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    output bus_dec_t              dec,
    output logic [NUM_GROUPS-1:0] wr_set,
    output logic [NUM_GROUPS-1:0] wr_clr,
    output logic [NUM_GROUPS-1:0] wr_emask,
    output logic [NUM_GROUPS-1:0] wr_xmask
);

    assign dec = decode_addr(addr, NUM_GROUPS);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_strobe
        logic sel;
        assign sel         = wr_en && dec.hit && (dec.grp == GRP_SEL_W'(g));
        assign wr_set[g]   = sel && (dec.region == RG_SET);
        assign wr_clr[g]   = sel && (dec.region == RG_CLR);
        assign wr_emask[g] = sel && (dec.region == RG_EMASK);
        assign wr_xmask[g] = sel && (dec.region == RG_XMASK);
    end

endmodule

// File: rtl/evt_flag_group.sv
module evt_flag_group #(
    parameter int unsigned GROUP_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GROUP_W-1:0] ev,
    input  logic [GROUP_W-1:0] wdata,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic               wr_emask,
    input  logic               wr_xmask,
    output logic [GROUP_W-1:0] set_req,
    output logic [GROUP_W-1:0] clr_req,
    output logic [GROUP_W-1:0] flags,
    output logic [GROUP_W-1:0] emask,
    output logic [GROUP_W-1:0] xmask,
    output logic [GROUP_W-1:0] eview,
    output logic [GROUP_W-1:0] xview,
    output logic               irq,
    output logic               exc
);

    assign set_req = wr_set ? wdata : '0;
    assign clr_req = wr_clr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            emask <= '1;
            xmask <= '1;
        end else begin
            // Sources are OR-ed after the clear, so an arriving event wins.
            flags <= (flags & ~clr_req) | set_req | ev;
            if (wr_emask) emask <= wdata;
            if (wr_xmask) xmask <= wdata;
        end
    end

    assign eview = flags & ~emask;
    assign xview = flags & ~xmask;
    assign irq   = |eview;
    assign exc   = |xview;

endmodule

// File: rtl/evt_read_mux.sv
module evt_read_mux
    import evt_comb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_W    = 32,
    localparam int unsigned TOT_W     = NUM_GROUPS * GROUP_W
) (
    input  bus_dec_t           dec,
    input  logic [TOT_W-1:0]   flags_all,
    input  logic [TOT_W-1:0]   emask_all,
    input  logic [TOT_W-1:0]   xmask_all,
    input  logic [TOT_W-1:0]   eview_all,
    input  logic [TOT_W-1:0]   xview_all,
    output logic [GROUP_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (dec.hit && (dec.grp == GRP_SEL_W'(g))) begin
                unique case (dec.region)
                    RG_FLAG:  rdata = flags_all[g*GROUP_W +: GROUP_W];
                    RG_EMASK: rdata = emask_all[g*GROUP_W +: GROUP_W];
                    RG_EVIEW: rdata = eview_all[g*GROUP_W +: GROUP_W];
                    RG_XMASK: rdata = xmask_all[g*GROUP_W +: GROUP_W];
                    RG_XVIEW: rdata = xview_all[g*GROUP_W +: GROUP_W];
                    default:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_group_combiner.sv
module evt_group_combiner
    import evt_comb_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_W    = 32,
    localparam int unsigned NUM_EVENTS = NUM_GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_EVENTS-1:0] ev_in,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [GROUP_W-1:0]    bus_wdata,
    output logic [GROUP_W-1:0]    bus_rdata,
    output logic [NUM_GROUPS-1:0] grp_irq,
    output logic [NUM_GROUPS-1:0] grp_exc
);

    bus_dec_t              dec;
    logic [NUM_GROUPS-1:0] wr_set, wr_clr, wr_emask, wr_xmask;
    logic [NUM_EVENTS-1:0] flags_all, emask_all, xmask_all;
    logic [NUM_EVENTS-1:0] eview_all, xview_all;
    logic [NUM_EVENTS-1:0] set_req_all, clr_req_all;

    evt_addr_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
        .wr_en    (bus_we),
        .addr     (bus_addr),
        .dec      (dec),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .wr_emask (wr_emask),
        .wr_xmask (wr_xmask)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        evt_flag_group #(.GROUP_W(GROUP_W)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .ev       (ev_in[g*GROUP_W +: GROUP_W]),
            .wdata    (bus_wdata),
            .wr_set   (wr_set[g]),
            .wr_clr   (wr_clr[g]),
            .wr_emask (wr_emask[g]),
            .wr_xmask (wr_xmask[g]),
            .set_req  (set_req_all[g*GROUP_W +: GROUP_W]),
            .clr_req  (clr_req_all[g*GROUP_W +: GROUP_W]),
            .flags    (flags_all[g*GROUP_W +: GROUP_W]),
            .emask    (emask_all[g*GROUP_W +: GROUP_W]),
            .xmask    (xmask_all[g*GROUP_W +: GROUP_W]),
            .eview    (eview_all[g*GROUP_W +: GROUP_W]),
            .xview    (xview_all[g*GROUP_W +: GROUP_W]),
            .irq      (grp_irq[g]),
            .exc      (grp_exc[g])
        );
    end

    evt_read_mux #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_rmux (
        .dec       (dec),
        .flags_all (flags_all),
        .emask_all (emask_all),
        .xmask_all (xmask_all),
        .eview_all (eview_all),
        .xview_all (xview_all),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/evt_group_combiner_chk.sv
module evt_group_combiner_chk #(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned GROUP_W    = 32,
    localparam int unsigned TOT_W     = NUM_GROUPS * GROUP_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic [TOT_W-1:0]      ev_in,
    input logic [TOT_W-1:0]      flags_all,
    input logic [TOT_W-1:0]      emask_all,
    input logic [TOT_W-1:0]      xmask_all,
    input logic [TOT_W-1:0]      set_req_all,
    input logic [TOT_W-1:0]      clr_req_all,
    input logic [5:0]            bus_addr,
    input logic [GROUP_W-1:0]    bus_rdata,
    input logic [NUM_GROUPS-1:0] grp_irq,
    input logic [NUM_GROUPS-1:0] grp_exc
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst) begin
            AST_RESET_STATE: assert (flags_all == '0 && (&emask_all) && (&xmask_all)
                                     && grp_irq == '0 && grp_exc == '0)
                else $error("state after reset wrong"); // R1
        end
    end

    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags_all & $past(ev_in)) == $past(ev_in))); // R2

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags_all & ~$past(flags_all) & ~$past(ev_in) & ~$past(set_req_all)) == '0)); // R2

    AST_SET_WRITE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags_all & $past(set_req_all)) == $past(set_req_all))); // R3

    AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((flags_all & $past(clr_req_all) & ~$past(ev_in)) == '0)); // R4

    AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (&emask_all) |-> (grp_irq == '0)); // R8

    AST_EXC_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (&xmask_all) |-> (grp_exc == '0)); // R8

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr >> 3) == 6'd3) |-> (bus_rdata == '0)); // R9

endmodule

bind evt_group_combiner evt_group_combiner_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_W    (GROUP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_in       (ev_in),
    .flags_all   (flags_all),
    .emask_all   (emask_all),
    .xmask_all   (xmask_all),
    .set_req_all (set_req_all),
    .clr_req_all (clr_req_all),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .grp_irq     (grp_irq),
    .grp_exc     (grp_exc)
);

// File: tb/tb_evt_group_combiner.sv
module tb_evt_group_combiner;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 4;
    localparam int GW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NG*GW-1:0] ev_in = '0;
    logic            bus_we = 1'b0;
    logic [5:0]      bus_addr = '0;
    logic [GW-1:0]   bus_wdata = '0;
    logic [GW-1:0]   bus_rdata;
    logic [NG-1:0]   grp_irq, grp_exc;

    int n_cmp = 0;
    int n_bad = 0;

    logic [GW-1:0] mf [NG];
    logic [GW-1:0] mev [NG];
    logic [GW-1:0] mex [NG];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_group_combiner dut (
        .clk(clk), .rst(rst), .ev_in(ev_in), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .grp_irq(grp_irq), .grp_exc(grp_exc)
    );

    task automatic chk(string tag, logic [GW-1:0] act, logic [GW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [GW-1:0] exp_word(int r, int g);
        if (g >= NG) return '0;
        case (r)
            0: return mf[g];
            4: return mev[g];
            5: return mf[g] & ~mev[g];
            6: return mex[g];
            7: return mf[g] & ~mex[g];
            default: return '0;
        endcase
    endfunction

    // Drive at a falling edge, let one rising edge take it, release at the next falling edge.
    task automatic wr_ev(int r, int g, logic [GW-1:0] d, logic [NG*GW-1:0] ev);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = {r[2:0], g[2:0]}; bus_wdata = d; ev_in = ev;
        @(negedge clk);
        bus_we = 1'b0; ev_in = '0;
        if (g < NG) begin
            case (r)
                1: mf[g] = mf[g] | d;
                2: mf[g] = mf[g] & ~d;
                4: mev[g] = d;
                6: mex[g] = d;
                default: ;
            endcase
        end
        for (int k = 0; k < NG; k++) mf[k] = mf[k] | ev[k*GW +: GW];
    endtask

    task automatic wr(int r, int g, logic [GW-1:0] d);
        wr_ev(r, g, d, '0);
    endtask

    task automatic chk_outputs(string tag);
        logic [NG-1:0] ei, ex;
        for (int g = 0; g < NG; g++) begin
            ei[g] = |(mf[g] & ~mev[g]);
            ex[g] = |(mf[g] & ~mex[g]);
        end
        #1;
        chk({tag, " R8 irq"}, GW'(grp_irq), GW'(ei));
        chk({tag, " R8 exc"}, GW'(grp_exc), GW'(ex));
    endtask

    task automatic chk_all(string tag);
        for (int g = 0; g < 8; g++) begin
            for (int r = 0; r < 8; r++) begin
                bus_addr = {r[2:0], g[2:0]};
                #1;
                chk($sformatf("%s R10 R11 addr %0d", tag, r*8+g), bus_rdata, exp_word(r, g));
            end
        end
        chk_outputs(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int g = 0; g < NG; g++) begin mf[g] = '0; mev[g] = '1; mex[g] = '1; end
        ev_in = '1;          // events during reset must not be captured
        repeat (3) @(negedge clk);
        chk_all("R1 in reset");
        rst = 1'b0; ev_in = '0;
        chk_all("R1 after reset");

        // R6 R7: complementary mask patterns per group
        for (int g = 0; g < NG; g++) begin
            wr(4, g, 32'h5555_5555 << g);
            wr(6, g, ~(32'h5555_5555 << g));
        end
        chk_all("R6 R7 masks");

        // R2 R4 R8: walking event over every flag
        for (int b = 0; b < NG*GW; b++) begin
            logic [NG*GW-1:0] one;
            one = '0; one[b] = 1'b1;
            wr_ev(3, 0, '0, one);
            bus_addr = {3'd0, 3'(b / GW)}; #1;
            chk($sformatf("R2 walk bit %0d", b), bus_rdata, mf[b / GW]);
            chk_outputs($sformatf("R2 walk bit %0d", b));
            wr(2, b / GW, 32'(1) << (b % GW));
            bus_addr = {3'd0, 3'(b / GW)}; #1;
            chk($sformatf("R4 walk clear %0d", b), bus_rdata, '0);
        end

        // R3 R4: dense patterns and zero words
        for (int g = 0; g < NG; g++) wr(1, g, 32'hA5A5_0F0F ^ (32'h1111_1111 * g));
        chk_all("R3 set pattern");
        for (int g = 0; g < NG; g++) begin wr(1, g, '0); wr(2, g, '0); end
        chk_all("R3 R4 zero words");
        for (int g = 0; g < NG; g++) wr(2, g, 32'hFFFF_0000 >> g);
        chk_all("R4 partial clear");

        // R5: event coincides with clear of the whole group
        begin
            logic [NG*GW-1:0] ev;
            ev = '0; ev[GW + 5] = 1'b1; ev[2*GW + 31] = 1'b1;
            wr_ev(2, 1, '1, ev);
            bus_addr = 6'd1; #1;
            chk("R5 set wins", bus_rdata, 32'h0000_0020);
            wr_ev(2, 2, 32'h8000_0001, ev);
            chk_all("R5 set wins group 2");
        end

        // R9: writes to reserved, unpopulated and read-only words
        for (int g = 0; g < 8; g++) begin
            wr(3, g, '1);
            wr(0, g, '1);
            wr(5, g, '1);
            wr(7, g, '1);
        end
        for (int g = NG; g < 8; g++) begin
            wr(1, g, '1); wr(4, g, '0); wr(6, g, '0);
        end
        chk_all("R9 ignored writes");

        // R8: open all masks, then close them again
        for (int g = 0; g < NG; g++) begin wr(4, g, '0); wr(6, g, '0); end
        chk_all("R8 unmasked");
        for (int g = 0; g < NG; g++) begin wr(4, g, '1); wr(6, g, '1); end
        chk_all("R8 all masked");

        // R1: reset again with flags pending
        for (int g = 0; g < NG; g++) wr(1, g, '1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int g = 0; g < NG; g++) begin mf[g] = '0; mev[g] = '1; mex[g] = '1; end
        chk_all("R1 re-reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule